// File: doc/BRIEF.md
# Oscillator start/stop task controller

This block sequences two clock sources, a fast one and a slow one, through start and stop requests, and runs a one-shot calibration request for the slow RC source. Each source has its own four-state machine: off, ramping, on and draining. A request is accepted only in the states where it makes sense. Each source exposes a run-request bit and a status word. The status word carries a running flag and a source code in a fixed field. For the fast source that code is the crystal code. For the slow source it is a latched copy of a software-selected source.

Completion of a start, and completion of a calibration, each set a sticky event flag. An interrupt mask with separate set and clear write addresses gates these flags onto one level interrupt. Software drives the block through a simple word-addressed write/read port. Hardware can also fire the same requests with single-cycle strobes. A pulse marks the first tick of the slow clock.

Register map (word index, all writes act on `wr_data`):

| Index | Meaning |
|---|---|
| 0 / 1 | fast source start / stop request |
| 2 / 3 | slow source start / stop request |
| 4 | calibration request |
| 5 / 6 / 7 | event: fast started / slow started / calibration done |
| 8 / 9 | interrupt mask, set alias / clear alias |
| 10 / 11 | fast run bit / fast status |
| 12 / 13 | slow run bit / slow status |
| 14 / 15 | slow source select / latched source copy |

Top module: `osc_task_ctrl`

## Requirements
- R1: After reset both sources are off, and every run bit, status word, source register, mask bit, event flag, `irq` and `lf_first_tick` reads zero.
- R2: A fast start accepted in the off or draining state sets the fast run bit at the next edge and enters ramping. One edge later the source is on, the status word becomes bit 0 set plus the crystal code (default 1) at bit SRC_POS (default 16), giving 0x00010001, and the fast-started event (index 5) sets.
- R3: A fast start while ramping or on is ignored, so no new event is raised. A fast stop while off or draining is ignored.
- R4: A fast stop accepted while ramping or on clears the run bit at the next edge and enters draining. One edge later the source is off and the status word is zero, and no event is raised.
- R5: A slow start latches the source select (index 14, low SRC_W bits) into the copy register (index 15) and sets the slow run bit. One edge later the status word becomes bit 0 plus the copy at bit SRC_POS, the slow-started event (index 6) sets, and `lf_first_tick` is high for exactly that one cycle. A slow start is honoured in every state, and a later change of the select leaves the copy unchanged.
- R6: A slow stop accepted while ramping or on clears the slow run bit. One edge later only bit 0 of the slow status word clears, and the source field keeps its value.
- R7: A calibration request sets the calibration-done event (index 7) two edges after the request edge. A request made while one is in flight is not checked.
- R8: Event flags stay set until software writes index 5, 6 or 7 with bit 0 clear. A hardware set wins over a simultaneous software write.
- R9: Writing index 8 ORs `wr_data` bits into the mask and writing index 9 clears them. The mask bits are 0 = fast started, 1 = slow started, 2 = calibration done, and both indices read back the current mask.
- R10: `irq` is registered. It is high one edge after any event flag and its mask bit are both set, and low one edge after no such pair remains.
- R11: A request register acts only when written with a non-zero value, reads back zero, and is ORed with its hardware strobe input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | register write index |
| wr_data | input | DATA_W | register write data |
| rd_addr | input | ADDR_W | register read index |
| rd_data | output | DATA_W | registered read data, one cycle after `rd_addr` |
| hw_hf_start | input | 1 | hardware fast start strobe |
| hw_hf_stop | input | 1 | hardware fast stop strobe |
| hw_lf_start | input | 1 | hardware slow start strobe |
| hw_lf_stop | input | 1 | hardware slow stop strobe |
| hw_cal | input | 1 | hardware calibration strobe |
| irq | output | 1 | level interrupt |
| lf_first_tick | output | 1 | one-cycle pulse when the slow source comes on |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 4-bit index, a 2-bit source field at bit 16 and crystal code 1. This places every status word at a distinct, easily recognised value. The bench walks every index of the 16-word map. It samples the status words on both sides of the ramp edge, so the one-step delay to the on state is pinned down. It also covers a stop landing during ramping, requests made in states where they must be ignored, a latched source surviving a later select change, and the interrupt following flag-and-mask pairs in both directions.

// File: rtl/osc_task_pkg.sv
package osc_task_pkg;
  typedef enum logic [1:0] {
    CK_OFF   = 2'd0,
    CK_RAMP  = 2'd1,
    CK_ON    = 2'd2,
    CK_DRAIN = 2'd3
  } ck_state_e;

  // Event slots: order fixes mask bit positions.
  localparam int EV_HF  = 0;
  localparam int EV_LF  = 1;
  localparam int EV_CAL = 2;
  localparam int NUM_EV = 3;
endpackage

// File: rtl/osc_clk_fsm.sv
module osc_clk_fsm
  import osc_task_pkg::*;
#(
  parameter bit RESTART_OK = 1'b0  // 1: start honoured in every state
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      stop_i,
  output ck_state_e state_o,
  output logic      run_o,
  output logic      up_o,    // entering on at this edge
  output logic      down_o   // entering off at this edge
);
  ck_state_e state_q, state_n;
  logic      run_q, run_n;

  always_comb begin
    state_n = state_q;
    run_n   = run_q;
    up_o    = 1'b0;
    down_o  = 1'b0;
    case (state_q)
      CK_OFF: begin
        if (start_i) begin
          state_n = CK_RAMP;
          run_n   = 1'b1;
        end
      end
      CK_RAMP: begin
        if (stop_i) begin
          state_n = CK_DRAIN;
          run_n   = 1'b0;
        end else if (start_i && RESTART_OK) begin
          state_n = CK_RAMP;
        end else begin
          state_n = CK_ON;
          up_o    = 1'b1;
        end
      end
      CK_ON: begin
        if (stop_i) begin
          state_n = CK_DRAIN;
          run_n   = 1'b0;
        end else if (start_i && RESTART_OK) begin
          state_n = CK_RAMP;
          run_n   = 1'b1;
        end
      end
      default: begin
        if (start_i) begin
          state_n = CK_RAMP;
          run_n   = 1'b1;
        end else begin
          state_n = CK_OFF;
          down_o  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CK_OFF;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      run_q   <= run_n;
    end
  end

  assign state_o = state_q;
  assign run_o   = run_q;

  a_r2_leave_off: assert property (@(posedge clk) disable iff (rst)
    (state_q == CK_OFF && start_i) |=> (state_q == CK_RAMP && run_q));
  a_r2_ramp_done: assert property (@(posedge clk) disable iff (rst)
    (state_q == CK_RAMP && !stop_i && !(start_i && RESTART_OK)) |=> state_q == CK_ON);
  a_r3_on_holds: assert property (@(posedge clk) disable iff (rst)
    (!RESTART_OK && state_q == CK_ON && !stop_i) |=> state_q == CK_ON);
  a_r4_stop_drains: assert property (@(posedge clk) disable iff (rst)
    ((state_q == CK_ON || state_q == CK_RAMP) && stop_i) |=> (state_q == CK_DRAIN && !run_q));
endmodule

// File: rtl/osc_evt_bank.sv
module osc_evt_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] sw_we_i,
  input  logic         sw_bit_i,
  input  logic         mask_set_i,
  input  logic         mask_clr_i,
  input  logic [N-1:0] mask_data_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] mask_q;
  logic         irq_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flag_q[i] <= 1'b0;
      else if (hw_set_i[i]) flag_q[i] <= 1'b1;
      else if (sw_we_i[i])  flag_q[i] <= sw_bit_i;
    end

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !sw_we_i[i]) |=> flag_q[i]);
    a_r8_hw_wins: assert property (@(posedge clk) disable iff (rst)
      hw_set_i[i] |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_set_i)      mask_q <= mask_q | mask_data_i;
      else if (mask_clr_i) mask_q <= mask_q & ~mask_data_i;
      irq_q <= |(flag_q & mask_q);
    end
  end

  assign flags_o = flag_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  a_r9_clear_alias: assert property (@(posedge clk) disable iff (rst)
    (mask_clr_i && !mask_set_i) |=> ((mask_q & $past(mask_data_i)) == '0));
  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & mask_q) == '0) |=> !irq_q);
  a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & mask_q) != '0) |=> irq_q);
endmodule

// File: rtl/osc_task_ctrl.sv
module osc_task_ctrl
  import osc_task_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int SRC_W     = 2,
  parameter int SRC_POS   = 16,
  parameter int XTAL_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              hw_hf_start,
  input  logic              hw_hf_stop,
  input  logic              hw_lf_start,
  input  logic              hw_lf_stop,
  input  logic              hw_cal,
  output logic              irq,
  output logic              lf_first_tick
);
  localparam logic [ADDR_W-1:0] A_HF_GO   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HF_HALT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LF_GO   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LF_HALT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CAL_GO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_EV_BASE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MSET    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_MCLR    = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_HF_RUN  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_HF_STAT = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_LF_RUN  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_LF_STAT = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_LF_SEL  = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_LF_COPY = ADDR_W'(15);
  localparam logic [SRC_W-1:0]  XTAL      = SRC_W'(XTAL_CODE);

  function automatic logic [DATA_W-1:0] stat_word(input logic [SRC_W-1:0] src);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = 1'b1;
    w[SRC_POS +: SRC_W] = src;
    return w;
  endfunction

  // Request decode: non-zero register write ORed with hardware strobe.
  logic wr_nz;
  logic hf_go, hf_halt, lf_go, lf_halt, cal_go;
  assign wr_nz   = wr_en && (wr_data != '0);
  assign hf_go   = hw_hf_start | (wr_nz && wr_addr == A_HF_GO);
  assign hf_halt = hw_hf_stop  | (wr_nz && wr_addr == A_HF_HALT);
  assign lf_go   = hw_lf_start | (wr_nz && wr_addr == A_LF_GO);
  assign lf_halt = hw_lf_stop  | (wr_nz && wr_addr == A_LF_HALT);
  assign cal_go  = hw_cal      | (wr_nz && wr_addr == A_CAL_GO);

  ck_state_e hf_state, lf_state;
  logic      hf_run, hf_up, hf_down;
  logic      lf_run, lf_up, lf_down;

  osc_clk_fsm #(.RESTART_OK(1'b0)) u_hf_fsm (
    .clk(clk), .rst(rst), .start_i(hf_go), .stop_i(hf_halt),
    .state_o(hf_state), .run_o(hf_run), .up_o(hf_up), .down_o(hf_down));

  osc_clk_fsm #(.RESTART_OK(1'b1)) u_lf_fsm (
    .clk(clk), .rst(rst), .start_i(lf_go), .stop_i(lf_halt),
    .state_o(lf_state), .run_o(lf_run), .up_o(lf_up), .down_o(lf_down));

  logic [DATA_W-1:0] hf_stat, lf_stat;
  logic [SRC_W-1:0]  lf_sel, lf_copy;
  logic              cal_busy, tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hf_stat  <= '0;
      lf_stat  <= '0;
      lf_sel   <= '0;
      lf_copy  <= '0;
      cal_busy <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_LF_SEL) lf_sel <= wr_data[SRC_W-1:0];
      if (lf_go) lf_copy <= lf_sel;
      if (hf_up)        hf_stat <= stat_word(XTAL);
      else if (hf_down) hf_stat <= '0;
      if (lf_up)        lf_stat <= stat_word(lf_copy);
      else if (lf_down) lf_stat[0] <= 1'b0;
      cal_busy <= cal_go;
      tick_q   <= lf_up;
    end
  end

  // Event bank
  logic [NUM_EV-1:0] ev_set, ev_we, ev_flags, ev_mask;
  always_comb begin
    ev_set         = '0;
    ev_set[EV_HF]  = hf_up;
    ev_set[EV_LF]  = lf_up;
    ev_set[EV_CAL] = cal_busy;
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evwe
    assign ev_we[i] = wr_en && (wr_addr == A_EV_BASE + ADDR_W'(i));
  end

  osc_evt_bank #(.N(NUM_EV)) u_evt (
    .clk(clk), .rst(rst), .hw_set_i(ev_set), .sw_we_i(ev_we),
    .sw_bit_i(wr_data[0]),
    .mask_set_i(wr_en && wr_addr == A_MSET),
    .mask_clr_i(wr_en && wr_addr == A_MCLR),
    .mask_data_i(wr_data[NUM_EV-1:0]),
    .flags_o(ev_flags), .mask_o(ev_mask), .irq_o(irq));

  // Registered readback
  logic [DATA_W-1:0] rd_n, rd_q;
  always_comb begin
    rd_n = '0;
    case (rd_addr)
      A_EV_BASE:                rd_n[0] = ev_flags[EV_HF];
      A_EV_BASE + ADDR_W'(1):   rd_n[0] = ev_flags[EV_LF];
      A_EV_BASE + ADDR_W'(2):   rd_n[0] = ev_flags[EV_CAL];
      A_MSET, A_MCLR:           rd_n[NUM_EV-1:0] = ev_mask;
      A_HF_RUN:                 rd_n[0] = hf_run;
      A_HF_STAT:                rd_n = hf_stat;
      A_LF_RUN:                 rd_n[0] = lf_run;
      A_LF_STAT:                rd_n = lf_stat;
      A_LF_SEL:                 rd_n[SRC_W-1:0] = lf_sel;
      A_LF_COPY:                rd_n[SRC_W-1:0] = lf_copy;
      default:                  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign rd_data       = rd_q;
  assign lf_first_tick = tick_q;

  a_r7_cal_done: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> ev_flags[EV_CAL]);
  a_r5_tick_event: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (ev_flags[EV_LF] && lf_stat[0]));
  a_r5_tick_single: assert property (@(posedge clk) disable iff (rst)
    (tick_q && !lf_up) |=> !tick_q);
  a_r6_keep_source: assert property (@(posedge clk) disable iff (rst)
    (lf_down && !lf_up) |=> (!lf_stat[0] &&
      lf_stat[SRC_POS +: SRC_W] == $past(lf_stat[SRC_POS +: SRC_W])));
  a_r11_zero_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_HF_GO && wr_data == '0 && !hw_hf_start && hf_state == CK_OFF)
      |=> hf_state == CK_OFF);
  a_r4_lf_stop: assert property (@(posedge clk) disable iff (rst)
    (lf_state == CK_ON && lf_halt) |=> !lf_run);
endmodule

// File: tb/test_osc_task_ctrl.sv
module test_osc_task_ctrl;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic hw_hf_start = 1'b0, hw_hf_stop = 1'b0, hw_lf_start = 1'b0;
  logic hw_lf_stop = 1'b0, hw_cal = 1'b0;
  logic irq, lf_first_tick;

  always #4 clk = ~clk;

  osc_task_ctrl i_osc_task_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .hw_hf_start(hw_hf_start), .hw_hf_stop(hw_hf_stop),
    .hw_lf_start(hw_lf_start), .hw_lf_stop(hw_lf_stop), .hw_cal(hw_cal),
    .irq(irq), .lf_first_tick(lf_first_tick));

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_req = 1'b0;
  logic          mon_arm = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: compares each registered read result against the scoreboard.
  always @(posedge clk) mon_arm <= rd_req;
  always @(negedge clk) begin
    if (mon_arm && exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    rd_addr = a; rd_req = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    rd(4'd10, 0, "R1 hf run");
    rd(4'd11, 0, "R1 hf stat");
    rd(4'd13, 0, "R1 lf stat");
    rd(4'd8,  0, "R1 mask");
    rd(4'd5,  0, "R1 hf event");
    chk("R1 irq", DW'(irq), 0);
    chk("R1 tick", DW'(lf_first_tick), 0);

    // R11 zero write ignored
    wr(4'd0, 0);
    idle(2);
    rd(4'd10, 0, "R11 zero write");

    // R2 fast start timing
    wr(4'd0, 1);
    rd(4'd11, 0, "R2 stat still ramping");
    rd(4'd11, 32'h0001_0001, "R2 stat on");
    rd(4'd10, 1, "R2 run");
    rd(4'd5,  1, "R2 event");
    rd(4'd0,  0, "R11 request reads zero");
    idle(5);
    rd(4'd5, 1, "R8 sticky");
    chk("R10 irq masked", DW'(irq), 0);
    wr(4'd8, 1);
    idle(1);
    chk("R10 irq high", DW'(irq), 1);
    wr(4'd5, 0);
    idle(1);
    chk("R10 irq low", DW'(irq), 0);
    rd(4'd5, 0, "R8 sw clear");

    // R3 start while on ignored
    wr(4'd0, 1);
    idle(3);
    rd(4'd5,  0, "R3 no new event");
    rd(4'd11, 32'h0001_0001, "R3 stat kept");

    // R4 stop
    wr(4'd1, 1);
    rd(4'd10, 0, "R4 run cleared");
    rd(4'd11, 0, "R4 stat cleared");
    rd(4'd5,  0, "R4 no event");
    // R3 stop while off ignored, then stop during ramp aborts
    wr(4'd1, 1);
    idle(2);
    rd(4'd11, 0, "R3 stop off");
    wr(4'd0, 1);
    wr(4'd1, 1);
    idle(3);
    rd(4'd5,  0, "R4 abort no event");
    rd(4'd11, 0, "R4 abort stat");

    // R11 hardware strobes
    hw_hf_start = 1'b1;
    @(negedge clk);
    hw_hf_start = 1'b0;
    idle(2);
    rd(4'd11, 32'h0001_0001, "R11 hw start");
    rd(4'd5,  1, "R11 hw event");
    wr(4'd5, 0);
    hw_hf_stop = 1'b1;
    @(negedge clk);
    hw_hf_stop = 1'b0;
    idle(2);
    rd(4'd11, 0, "R11 hw stop");

    // R5 slow start
    wr(4'd14, 2);
    wr(4'd2, 1);
    chk("R5 tick not yet", DW'(lf_first_tick), 0);
    @(negedge clk);
    chk("R5 tick pulse", DW'(lf_first_tick), 1);
    @(negedge clk);
    chk("R5 tick ends", DW'(lf_first_tick), 0);
    rd(4'd15, 2, "R5 copy");
    rd(4'd13, 32'h0002_0001, "R5 stat");
    rd(4'd6,  1, "R5 event");
    rd(4'd12, 1, "R5 run");
    wr(4'd14, 3);
    rd(4'd15, 2, "R5 copy holds");
    rd(4'd14, 3, "R5 select");

    // R6 slow stop
    wr(4'd3, 1);
    idle(2);
    rd(4'd13, 32'h0002_0000, "R6 stat source kept");
    rd(4'd12, 0, "R6 run");
    wr(4'd2, 1);
    idle(3);
    rd(4'd13, 32'h0003_0001, "R5 restart new source");

    // R7 / R9 calibration and mask
    wr(4'd8, 4);
    rd(4'd9, 5, "R9 mask via clear alias");
    wr(4'd4, 1);
    idle(2);
    chk("R7 irq on done", DW'(irq), 1);
    rd(4'd7, 1, "R7 done event");
    wr(4'd9, 4);
    idle(1);
    chk("R9 irq masked off", DW'(irq), 0);
    rd(4'd8, 1, "R9 mask via set alias");
    rd(4'd7, 1, "R8 done sticky");
    idle(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule